// File: doc/BRIEF.md
# Tag-checked programmable functional unit

This block is an extra execution unit placed beside a processor's register file. It reads two source operands, receives a user-defined function number with each issue, and returns one result to the register file. Its datapath is a grid of 4-input lookup tables with no pipeline registers and no operand state. The result therefore appears in the same cycle the operands are presented, but only when the requested function number equals the number of the configuration currently loaded. Any other request raises a fault instead, so that trap software can load the wanted function and retry.

The function itself and its 11-bit number arrive over a one-bit serial load port. The number is the last part of the stream. The unit refuses every issue from the moment a load starts until its final bit has been taken. No operand state is kept, so a context switch needs no save or restore. A new context simply takes a fault on its first use of a function that is not resident.

Top module: `pfu_top`

## Requirements
- R1: After reset, and after a reset that cuts off a load part-way, every issue faults until a complete configuration stream has been loaded.
- R2: An issue whose function number differs from the loaded number asserts `fault` in the same cycle, with `result_valid` low and `result` zero.
- R3: An issue whose function number equals the loaded number, with no load in progress, asserts `result_valid` in the same cycle and drives the table-computed value on `result`, with `fault` low.
- R4: With `issue_valid` low, `fault` and `result_valid` are low and `result` is zero, whatever the other inputs are.
- R5: From the clock edge that takes the first bit of a load until the edge that takes its last bit, every issue faults. Gaps with `cfg_load` low leave the load in progress.
- R6: A load is exactly ROWS*DATA_W*16+11 bits, counted at edges where `cfg_load` is high. Stream bit k, for k below ROWS*DATA_W*16, is entry k%16 of the table for row k/(16*DATA_W), column (k/16)%DATA_W. The final 11 bits are the function number, least significant bit first. Reloading replaces both the tables and the number.
- R7: Each row has one table per bit column i. A table reads the entry indexed by {p[i], b[i], p[i-1], b[i-1]}, with bit 3 first and the column below 0 wrapping to DATA_W-1. Here b is `src_b`, and p is `src_a` for row 0 or the previous row's outputs for later rows. `result` is the last row's output.
- R8: A result depends only on the operands and function number of its own cycle; earlier issues have no effect on it.
- R9: Whenever `issue_valid` is high, exactly one of `fault` and `result_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration bit strobe |
| cfg_bit | input | 1 | Configuration bit, in stream order |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_fid | input | 11 | Requested function number |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand |
| result | output | DATA_W | Computed value, zero when not valid |
| result_valid | output | 1 | Result is valid this cycle |
| fault | output | 1 | Requested function is not resident |

## Verification
The bench checks function numbers that differ from the resident one by a single bit, as well as the all-ones and all-zeros numbers. A comparison that ignored any bit of the number would return a result where a fault is due. It issues the resident number during a load, and inside gaps in the load. A unit that kept its ready flag set while loading would compute from tables that are half shifted in. It also reloads a new function and retries the old number, and it applies a reset in the middle of a load. A unit whose stream order or table index was wrong shows a wrong `result` bit against the bench model for the all-zeros, all-ones, alternating and random operand patterns. The wrap-around neighbour of column 0 is one such bit.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int LUT_IN   = 4;
  localparam int LUT_BITS = 1 << LUT_IN;

  function automatic logic lut_pick(input logic [LUT_BITS-1:0] tbl,
                                    input logic [LUT_IN-1:0] sel);
    return tbl[sel];
  endfunction
endpackage

// File: rtl/pfu_cfg_chain.sv
module pfu_cfg_chain #(
  parameter int TOTAL = 1547,
  parameter int CNT_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  output logic [TOTAL-1:0] chain,
  output logic [CNT_W-1:0] load_cnt,
  output logic             ready
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  // Configuration storage carries no reset; ready gates its use.
  always_ff @(posedge clk) begin
    if (cfg_load) chain <= {cfg_bit, chain[TOTAL-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_cnt <= '0;
      ready    <= 1'b0;
    end else if (cfg_load) begin
      if (load_cnt == LAST) begin
        load_cnt <= '0;
        ready    <= 1'b1;
      end else begin
        load_cnt <= load_cnt + 1'b1;
        ready    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfu_lut_row.sv
module pfu_lut_row
  import pfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W*LUT_BITS-1:0] tables,
  input  logic [DATA_W-1:0]          p_in,
  input  logic [DATA_W-1:0]          q_in,
  output logic [DATA_W-1:0]          row_out
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam int PREV = (i + DATA_W - 1) % DATA_W;
    logic [LUT_IN-1:0] sel;
    assign sel        = {p_in[i], q_in[i], p_in[PREV], q_in[PREV]};
    assign row_out[i] = lut_pick(tables[i*LUT_BITS +: LUT_BITS], sel);
  end
endmodule

// File: rtl/pfu_top.sv
module pfu_top
  import pfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ROWS   = 3,
  parameter int FID_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic              cfg_bit,
  input  logic              issue_valid,
  input  logic [FID_W-1:0]  issue_fid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              fault
);
  localparam int ROW_BITS = DATA_W * LUT_BITS;
  localparam int TBL_BITS = ROWS * ROW_BITS;
  localparam int TOTAL    = TBL_BITS + FID_W;
  localparam int CNT_W    = $clog2(TOTAL);

  logic [TOTAL-1:0]  chain;
  logic [CNT_W-1:0]  load_cnt;
  logic              ready;
  logic [FID_W-1:0]  resident_fid;
  logic [DATA_W-1:0] stage [ROWS+1];
  logic              hit;

  pfu_cfg_chain #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_bit  (cfg_bit),
    .chain    (chain),
    .load_cnt (load_cnt),
    .ready    (ready)
  );

  assign resident_fid = chain[TOTAL-1 -: FID_W];
  assign stage[0]     = src_a;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    pfu_lut_row #(.DATA_W(DATA_W)) u_row (
      .tables  (chain[r*ROW_BITS +: ROW_BITS]),
      .p_in    (stage[r]),
      .q_in    (src_b),
      .row_out (stage[r+1])
    );
  end

  assign hit          = ready && (issue_fid == resident_fid);
  assign result_valid = issue_valid && hit;
  assign fault        = issue_valid && !hit;
  assign result       = result_valid ? stage[ROWS] : '0;
endmodule

// File: rtl/pfu_sva.sv
module pfu_sva #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic              fault,
  input logic              result_valid,
  input logic [DATA_W-1:0] result,
  input logic [CNT_W-1:0]  load_cnt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> (!fault && !result_valid && result == '0)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> $countones({fault, result_valid}) == 1); // R9
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    fault |-> (result == '0 && !result_valid)); // R2
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (load_cnt != '0 && issue_valid) |-> fault); // R5
  AST_RESET_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && issue_valid) |-> fault); // R1
endmodule

bind pfu_top pfu_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .issue_valid  (issue_valid),
  .fault        (fault),
  .result_valid (result_valid),
  .result       (result),
  .load_cnt     (load_cnt)
);

// File: tb/pfu_top_tb.sv
module pfu_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 32;
  localparam int ROWS = 3;
  localparam int FW   = 11;
  localparam int LB   = ROWS * W * 16;
  localparam int TOT  = LB + FW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic          cfg_bit = 1'b0;
  logic          issue_valid = 1'b0;
  logic [FW-1:0] issue_fid = '0;
  logic [W-1:0]  src_a = '0;
  logic [W-1:0]  src_b = '0;
  logic [W-1:0]  result;
  logic          result_valid;
  logic          fault;

  int checks = 0;
  int errors = 0;

  bit m_cfg [TOT];
  bit m_pend [TOT];
  int m_cnt = 0;
  bit m_ok = 0;

  pfu_top #(.DATA_W(W), .ROWS(ROWS), .FID_W(FW)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .issue_valid(issue_valid), .issue_fid(issue_fid),
    .src_a(src_a), .src_b(src_b),
    .result(result), .result_valid(result_valid), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] m_fid();
    logic [FW-1:0] f;
    for (int j = 0; j < FW; j++) f[j] = m_cfg[LB + j];
    return f;
  endfunction

  function automatic logic [W-1:0] m_eval(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] p, o;
    p = a;
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i < W; i++) begin
        int pv, idx;
        pv  = (i + W - 1) % W;
        idx = {p[i], b[i], p[pv], b[pv]};
        o[i] = m_cfg[(r * W + i) * 16 + idx];
      end
      p = o;
    end
    return p;
  endfunction

  task automatic cyc(bit cv, bit cd, bit iv, logic [FW-1:0] fid,
                     logic [W-1:0] a, logic [W-1:0] b, string tag);
    bit hit;
    logic [W-1:0] e_res;
    @(negedge clk);
    cfg_load = cv; cfg_bit = cd; issue_valid = iv;
    issue_fid = fid; src_a = a; src_b = b;
    #1;
    if (!rst) begin
      hit   = iv && m_ok && (fid == m_fid());
      e_res = hit ? m_eval(a, b) : '0;
      checks++;
      if (result !== e_res || result_valid !== hit || fault !== (iv && !hit)) begin
        errors++;
        $display("FAIL %s: res=%h rv=%b flt=%b expected res=%h rv=%b flt=%b",
                 tag, result, result_valid, fault, e_res, hit, iv && !hit);
      end
    end
    @(posedge clk);
    if (rst) begin
      m_cnt = 0; m_ok = 0;
    end else if (cv) begin
      m_pend[m_cnt] = cd;
      if (m_cnt == TOT - 1) begin
        m_cfg = m_pend; m_ok = 1; m_cnt = 0;
      end else begin
        m_cnt++; m_ok = 0;
      end
    end
  endtask

  // Stream a configuration; optional gaps, issues of 'probe' during the load.
  task automatic load(logic [FW-1:0] id, logic [FW-1:0] probe, int cut);
    for (int k = 0; k < TOT; k++) begin
      bit d;
      if (cut >= 0 && k == cut) return;
      d = (k < LB) ? 1'($urandom % 2) : id[k - LB];
      if (k % 97 == 5) cyc(0, 0, 1, probe, $urandom, $urandom, "R5");
      cyc(1, d, (k % 13 == 0), probe, $urandom, $urandom, "R5");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pat [4];
    pat[0] = '0; pat[1] = '1; pat[2] = 32'h5555_5555; pat[3] = 32'h8000_0001;

    rst = 1'b1;
    repeat (3) cyc(0, 0, 0, '0, '0, '0, "R1");
    rst = 1'b0;
    // R1: nothing loaded yet
    cyc(0, 0, 1, 11'h000, 32'h1, 32'h2, "R1");
    cyc(0, 0, 1, 11'h7FF, '1, '1, "R1");
    // R4: idle with busy inputs
    cyc(0, 0, 0, 11'h123, '1, 32'hA5A5_A5A5, "R4");

    // R5/R6: first load with gaps and probes
    load(11'h123, 11'h123, -1);
    // R3/R7: operand patterns
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++)
        cyc(0, 0, 1, 11'h123, pat[x], pat[y], "R3_R7");
    for (int n = 0; n < 40; n++) cyc(0, 0, 1, 11'h123, $urandom, $urandom, "R3");
    // R8: back-to-back, then repeat earlier operands
    cyc(0, 0, 1, 11'h123, 32'hDEAD_BEEF, 32'h0123_4567, "R8");
    cyc(0, 0, 1, 11'h123, 32'hFFFF_0000, 32'h00FF_FF00, "R8");
    cyc(0, 0, 0, 11'h123, 32'h1234_5678, 32'h9ABC_DEF0, "R4");
    cyc(0, 0, 1, 11'h123, 32'hDEAD_BEEF, 32'h0123_4567, "R8");
    // R2: near-miss and extreme numbers
    for (int j = 0; j < FW; j++)
      cyc(0, 0, 1, 11'h123 ^ (11'h1 << j), $urandom, $urandom, "R2");
    cyc(0, 0, 1, 11'h7FF, $urandom, $urandom, "R2");
    cyc(0, 0, 1, 11'h000, $urandom, $urandom, "R2");
    cyc(0, 0, 0, 11'h000, $urandom, $urandom, "R4");

    // R6: reload another function, old number must fault
    load(11'h7FF, 11'h123, -1);
    cyc(0, 0, 1, 11'h123, $urandom, $urandom, "R6");
    for (int n = 0; n < 20; n++) cyc(0, 0, 1, 11'h7FF, $urandom, $urandom, "R6");
    cyc(0, 0, 1, 11'h7FF, '0, '0, "R6");
    cyc(0, 0, 1, 11'h7FF, '1, '0, "R6");

    // R1: reset part-way through a load
    load(11'h456, 11'h456, 600);
    rst = 1'b1;
    cyc(0, 0, 0, '0, '0, '0, "R1");
    rst = 1'b0;
    cyc(0, 0, 1, 11'h7FF, $urandom, $urandom, "R1");
    cyc(0, 0, 1, 11'h456, $urandom, $urandom, "R1");
    load(11'h456, 11'h456, -1);
    for (int n = 0; n < 10; n++) cyc(0, 0, 1, 11'h456, $urandom, $urandom, "R9");
    cyc(0, 0, 1, 11'h7FF, $urandom, $urandom, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule